// File: doc/BRIEF.md
# Nine-Bit Serial Port with Address Filtering

This block is a full-duplex asynchronous serial port. It sends and receives frames that start with a low start bit and carry eight data bits, least significant bit first. A ninth bit may follow the data, and the frame ends with a high stop bit. The ninth bit passes end to end. On transmit it comes from a dedicated input. On receive it is captured into an output that sits beside the received byte. A two-bit mode input chooses among three frame options: eight data bits with the bit rate set by an external 16x tick, nine bits with that same external tick, or nine bits at a fixed rate derived from the system clock.

The receiver can filter addresses for multiprocessor links. While the filter enable is high, a nine-bit frame whose ninth bit is 0 is dropped without any sign that it arrived. A frame whose ninth bit is 1 is delivered normally. A listening node therefore sees only address frames. Once it recognises its own address, it lowers the enable and then takes every frame that follows. The receiver also reports framing errors and overruns. Software acknowledges a received frame with a one-cycle strobe.

Top module: `mpuart`

## Requirements
- R1: After reset, `txd` is high and `tx_busy`, `rx_done`, `rx_ferr` and `rx_ovr` are low. `txd` stays high whenever `tx_busy` is low.
- R2: A transmitted frame is a 0 start bit, then `tx_data` bit 0 through bit 7, then (in nine-bit modes only) `tx_bit9`, then stop bits at 1.
- R3: `tx_busy` rises the cycle after `tx_load` is sampled while idle. It falls when the last stop bit ends: after 10, 11 or 12 bit times, counting one extra bit for the ninth bit and one for `two_stop`=1. A `tx_load` while busy is ignored.
- R4: `mode_sel` encoding: 2'b00 selects eight bits at the external rate, 2'b01 nine bits at the external rate, 2'b10 nine bits at the fixed rate, and 2'b11 behaves as 2'b01. At the external rate, one bit lasts 16 pulses of `tick16_i`.
- R5: In fixed-rate mode, a bit lasts 32 system clocks when `rate_dbl`=1 and 64 clocks when `rate_dbl`=0. `tick16_i` has no effect.
- R6: A received frame sets `rx_done` and loads `rx_data` and `rx_bit9`. In eight-bit mode, `rx_bit9` reads 0.
- R7: A low level on `rxd` is accepted as a start bit only if it is still low 8 ticks after it is first seen. A shorter low pulse produces no frame.
- R8: With `mp_en`=1 in a nine-bit mode, a frame whose ninth bit is 0 leaves `rx_done`, `rx_data`, `rx_bit9` and `rx_ovr` unchanged.
- R9: With `mp_en`=1, a frame whose ninth bit is 1 is delivered and sets `rx_done`.
- R10: With `mp_en`=0, every frame is delivered, including those whose ninth bit is 0. In eight-bit mode `mp_en` has no effect.
- R11: A stop bit sampled low sets `rx_ferr`, and the byte is still stored with `rx_done` set.
- R12: A frame that completes while `rx_done` is still set raises `rx_ovr` and keeps the old `rx_data`/`rx_bit9`. `rx_ack` clears both `rx_done` and `rx_ovr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | Frame and rate option (see R4) |
| rate_dbl | input | 1 | Fixed-rate doubling: 1 gives clk/32, 0 gives clk/64 |
| two_stop | input | 1 | Send two stop bits |
| mp_en | input | 1 | Address filter enable |
| tick16_i | input | 1 | 16x bit-rate enable pulse for the external-rate modes |
| tx_data | input | DW | Byte to send |
| tx_bit9 | input | 1 | Ninth bit to send |
| tx_load | input | 1 | Start a transmission |
| tx_busy | output | 1 | Transmission in progress |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_data | output | DW | Last delivered byte |
| rx_bit9 | output | 1 | Ninth bit of the last delivered frame |
| rx_done | output | 1 | Frame delivered and not yet acknowledged |
| rx_ack | input | 1 | Acknowledge strobe; clears `rx_done` and `rx_ovr` |
| rx_ferr | output | 1 | Stop bit of the stored frame was low |
| rx_ovr | output | 1 | A frame arrived while `rx_done` was still set |

## Verification
The hardest case to reach is a frame that is dropped by the address filter. Its only visible trace is that nothing changes. The bench therefore first delivers a known byte, then loops a filtered frame back from the transmitter. It checks that `rx_done` stays low and the earlier byte is still held, and then shows that a ninth-bit-1 frame, and a frame sent after the filter is cleared, both arrive. A second hard case is an overrun: it needs two complete frames with no acknowledge between them. A third is a start pulse too short to count. The bench drives `rxd` directly for these, with the pulse shorter than half a bit.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;

   typedef enum logic [1:0] {
      MODE_8_EXT  = 2'b00,
      MODE_9_EXT  = 2'b01,
      MODE_9_FIX  = 2'b10,
      MODE_9_EXT2 = 2'b11
   } mode_e;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP,
      RX_WAITHI
   } rx_state_e;

   function automatic logic mode_has_bit9(input logic [1:0] m);
      return m != MODE_8_EXT;
   endfunction

   function automatic logic mode_is_fixed(input logic [1:0] m);
      return m == MODE_9_FIX;
   endfunction

endpackage

// File: rtl/mpuart_baud.sv
module mpuart_baud #(
   parameter int OVS           = 16,
   parameter int FAST_BIT_CLKS = 32,
   parameter int SLOW_BIT_CLKS = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fixed_sel,
   input  logic rate_dbl,
   input  logic ext_tick,
   output logic tick
);
   localparam int FAST_DIV = FAST_BIT_CLKS / OVS;
   localparam int SLOW_DIV = SLOW_BIT_CLKS / OVS;
   localparam int CW       = $clog2(SLOW_DIV + 1);

   logic [CW-1:0] div_cnt;
   logic [CW-1:0] div_lim;
   logic          fix_tick;

   assign div_lim  = rate_dbl ? CW'(FAST_DIV - 1) : CW'(SLOW_DIV - 1);
   assign fix_tick = fixed_sel && (div_cnt >= div_lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_cnt <= '0;
      end else if (!fixed_sel || fix_tick) begin
         div_cnt <= '0;
      end else begin
         div_cnt <= div_cnt + 1'b1;
      end
   end

   assign tick = fixed_sel ? fix_tick : ext_tick;

endmodule

// File: rtl/mpuart_tx.sv
module mpuart_tx #(
   parameter int OVS = 16,
   parameter int DW  = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          load,
   input  logic [DW-1:0] data,
   input  logic          bit9,
   input  logic          nine,
   input  logic          two_stop,
   output logic          txd,
   output logic          busy
);
   localparam int FW  = DW + 4;
   localparam int TCW = $clog2(OVS);
   localparam int BCW = $clog2(FW + 1);

   logic [FW-1:0]  frame;
   logic [BCW-1:0] nbits;
   logic [FW-1:0]  sreg;
   logic [TCW-1:0] tcnt;
   logic [BCW-1:0] bleft;

   always_comb begin
      frame         = '1;
      frame[0]      = 1'b0;
      frame[DW:1]   = data;
      if (nine) begin
         frame[DW+1] = bit9;
      end
      nbits = BCW'(DW + 2) + BCW'(nine) + BCW'(two_stop);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         sreg  <= '1;
         tcnt  <= '0;
         bleft <= '0;
      end else if (!busy) begin
         if (load) begin
            busy  <= 1'b1;
            sreg  <= frame;
            bleft <= nbits;
            tcnt  <= '0;
         end
      end else if (tick) begin
         if (tcnt == TCW'(OVS - 1)) begin
            tcnt  <= '0;
            sreg  <= {1'b1, sreg[FW-1:1]};
            bleft <= bleft - 1'b1;
            if (bleft == BCW'(1)) begin
               busy <= 1'b0;
            end
         end else begin
            tcnt <= tcnt + 1'b1;
         end
      end
   end

   assign txd = sreg[0];

endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx
   import mpuart_pkg::*;
#(
   parameter int OVS  = 16,
   parameter int DW   = 8,
   parameter int SYNC = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          rxd,
   input  logic          nine_sel,
   input  logic          mp_en,
   input  logic          ack,
   output logic [DW-1:0] data,
   output logic          bit9,
   output logic          done,
   output logic          ferr,
   output logic          ovr,
   output logic          frame_nine
);
   localparam int TCW  = $clog2(OVS);
   localparam int BW   = $clog2(DW + 1);
   localparam int HALF = OVS / 2 - 1;

   logic            rx_s;
   rx_state_e       state;
   logic [TCW-1:0]  tcnt;
   logic [BW-1:0]   bidx;
   logic [DW:0]     shreg;
   logic            nine_q;
   logic            fin;
   logic            keep;
   logic            done_eff;
   logic [DW-1:0]   cap_data;

   generate
      if (SYNC == 1) begin : g_sync1
         logic s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= 1'b1;
            else        s_q <= rxd;
         end
         assign rx_s = s_q;
      end else begin : g_syncn
         logic [SYNC-1:0] s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= '1;
            else        s_q <= {s_q[SYNC-2:0], rxd};
         end
         assign rx_s = s_q[SYNC-1];
      end
   endgenerate

   assign fin      = (state == RX_STOP) && tick && (tcnt == TCW'(OVS - 1));
   assign keep     = !(nine_q && mp_en && !shreg[DW]);
   assign done_eff = done && !ack;
   assign cap_data = nine_q ? shreg[DW-1:0] : shreg[DW:1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= RX_IDLE;
         tcnt   <= '0;
         bidx   <= '0;
         shreg  <= '0;
         nine_q <= 1'b0;
      end else begin
         case (state)
            RX_IDLE: begin
               if (tick && !rx_s) begin
                  state <= RX_START;
                  tcnt  <= '0;
               end
            end
            RX_START: begin
               if (tick) begin
                  if (tcnt == TCW'(HALF)) begin
                     tcnt <= '0;
                     if (!rx_s) begin
                        state  <= RX_DATA;
                        bidx   <= '0;
                        nine_q <= nine_sel;
                     end else begin
                        state <= RX_IDLE;
                     end
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
            end
            RX_DATA: begin
               if (tick) begin
                  if (tcnt == TCW'(OVS - 1)) begin
                     tcnt  <= '0;
                     shreg <= {rx_s, shreg[DW:1]};
                     bidx  <= bidx + 1'b1;
                     if (bidx == (nine_q ? BW'(DW) : BW'(DW - 1))) begin
                        state <= RX_STOP;
                     end
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
            end
            RX_STOP: begin
               if (tick) begin
                  if (tcnt == TCW'(OVS - 1)) begin
                     tcnt  <= '0;
                     state <= rx_s ? RX_IDLE : RX_WAITHI;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
            end
            RX_WAITHI: begin
               if (rx_s) begin
                  state <= RX_IDLE;
               end
            end
            default: state <= RX_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data <= '0;
         bit9 <= 1'b0;
         done <= 1'b0;
         ferr <= 1'b0;
         ovr  <= 1'b0;
      end else begin
         if (ack) begin
            done <= 1'b0;
            ovr  <= 1'b0;
         end
         if (fin && keep) begin
            if (done_eff) begin
               ovr <= 1'b1;
            end else begin
               data <= cap_data;
               bit9 <= nine_q & shreg[DW];
               ferr <= !rx_s;
               done <= 1'b1;
            end
         end
      end
   end

   assign frame_nine = nine_q;

endmodule

// File: rtl/mpuart.sv
module mpuart
   import mpuart_pkg::*;
#(
   parameter int OVS           = 16,
   parameter int DW            = 8,
   parameter int FAST_BIT_CLKS = 32,
   parameter int SLOW_BIT_CLKS = 64,
   parameter int SYNC_STAGES   = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    mode_sel,
   input  logic          rate_dbl,
   input  logic          two_stop,
   input  logic          mp_en,
   input  logic          tick16_i,
   input  logic [DW-1:0] tx_data,
   input  logic          tx_bit9,
   input  logic          tx_load,
   output logic          tx_busy,
   output logic          txd,
   input  logic          rxd,
   output logic [DW-1:0] rx_data,
   output logic          rx_bit9,
   output logic          rx_done,
   input  logic          rx_ack,
   output logic          rx_ferr,
   output logic          rx_ovr
);
   generate
      if (OVS < 4 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
         $error("OVS must be a power of two, at least 4");
      end
      if (FAST_BIT_CLKS % OVS != 0 || SLOW_BIT_CLKS % OVS != 0) begin : g_bad_div
         $error("fixed bit lengths must be multiples of OVS");
      end
      if (FAST_BIT_CLKS > SLOW_BIT_CLKS) begin : g_bad_order
         $error("fast fixed bit must not be longer than slow fixed bit");
      end
      if (DW < 2) begin : g_bad_dw
         $error("DW must be at least 2");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic tick;
   logic rx_nine_w;
   logic nine_sel;

   assign nine_sel = mode_has_bit9(mode_sel);

   mpuart_baud #(
      .OVS          (OVS),
      .FAST_BIT_CLKS(FAST_BIT_CLKS),
      .SLOW_BIT_CLKS(SLOW_BIT_CLKS)
   ) u_baud (
      .clk      (clk),
      .rst_n    (rst_n),
      .fixed_sel(mode_is_fixed(mode_sel)),
      .rate_dbl (rate_dbl),
      .ext_tick (tick16_i),
      .tick     (tick)
   );

   mpuart_tx #(
      .OVS(OVS),
      .DW (DW)
   ) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .load    (tx_load),
      .data    (tx_data),
      .bit9    (tx_bit9),
      .nine    (nine_sel),
      .two_stop(two_stop),
      .txd     (txd),
      .busy    (tx_busy)
   );

   mpuart_rx #(
      .OVS (OVS),
      .DW  (DW),
      .SYNC(SYNC_STAGES)
   ) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .rxd       (rxd),
      .nine_sel  (nine_sel),
      .mp_en     (mp_en),
      .ack       (rx_ack),
      .data      (rx_data),
      .bit9      (rx_bit9),
      .done      (rx_done),
      .ferr      (rx_ferr),
      .ovr       (rx_ovr),
      .frame_nine(rx_nine_w)
   );

endmodule

// File: rtl/mpuart_chk.sv
module mpuart_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mp_en,
   input logic          tx_load,
   input logic          tx_busy,
   input logic          txd,
   input logic [DW-1:0] rx_data,
   input logic          rx_bit9,
   input logic          rx_done,
   input logic          rx_ovr,
   input logic          rx_nine
);

   a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> txd);

   a_r3_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_load && !tx_busy) |=> tx_busy);

   a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_busy) |-> !txd);

   a_r12_ovr_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ovr |-> rx_done);

   a_r12_ovr_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_ovr) |-> ($stable(rx_data) && $stable(rx_bit9)));

   a_r8_filter_needs_bit9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rx_done) && $past(mp_en) && $past(rx_nine)) |-> rx_bit9);

   a_r6_bit9_zero_in_8bit: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rx_done) && !$past(rx_nine)) |-> !rx_bit9);

endmodule

bind mpuart mpuart_chk #(.DW(DW)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .mp_en  (mp_en),
   .tx_load(tx_load),
   .tx_busy(tx_busy),
   .txd    (txd),
   .rx_data(rx_data),
   .rx_bit9(rx_bit9),
   .rx_done(rx_done),
   .rx_ovr (rx_ovr),
   .rx_nine(rx_nine_w)
);

// File: tb/mpuart_bench.sv
module mpuart_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode_sel = 2'b01;
   logic       rate_dbl = 1'b0;
   logic       two_stop = 1'b0;
   logic       mp_en = 1'b0;
   logic       tick16_i = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic       tx_bit9 = 1'b0;
   logic       tx_load = 1'b0;
   logic       tx_busy;
   logic       txd;
   logic       rxd;
   logic [7:0] rx_data;
   logic       rx_bit9;
   logic       rx_done;
   logic       rx_ack = 1'b0;
   logic       rx_ferr;
   logic       rx_ovr;
   logic       lb = 1'b0;
   logic       rx_drv = 1'b1;
   logic [1:0] tdiv = 2'd0;
   int         n_chk = 0;
   int         n_bad = 0;
   bit         finished = 1'b0;

   localparam int EXT_BIT = 64;

   always #4 clk = ~clk;

   assign rxd = lb ? txd : rx_drv;

   always @(negedge clk) begin
      tdiv     <= tdiv + 2'd1;
      tick16_i <= (tdiv == 2'd3);
   end

   mpuart u_mpuart (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .rate_dbl(rate_dbl),
      .two_stop(two_stop), .mp_en(mp_en), .tick16_i(tick16_i),
      .tx_data(tx_data), .tx_bit9(tx_bit9), .tx_load(tx_load),
      .tx_busy(tx_busy), .txd(txd), .rxd(rxd), .rx_data(rx_data),
      .rx_bit9(rx_bit9), .rx_done(rx_done), .rx_ack(rx_ack),
      .rx_ferr(rx_ferr), .rx_ovr(rx_ovr)
   );

   // {mode[1:0], rate_dbl, two_stop, mp_en, data[7:0], bit9, exp_done, exp_bit9}
   localparam int NV = 9;
   localparam logic [15:0] VEC [NV] = '{
      {2'd0, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b1, 1'b1, 1'b0},
      {2'd1, 1'b0, 1'b0, 1'b0, 8'h3C, 1'b1, 1'b1, 1'b1},
      {2'd1, 1'b0, 1'b1, 1'b0, 8'hC3, 1'b0, 1'b1, 1'b0},
      {2'd1, 1'b0, 1'b0, 1'b1, 8'h5A, 1'b0, 1'b0, 1'b0},
      {2'd1, 1'b0, 1'b0, 1'b1, 8'h81, 1'b1, 1'b1, 1'b1},
      {2'd0, 1'b0, 1'b1, 1'b1, 8'h7E, 1'b0, 1'b1, 1'b0},
      {2'd3, 1'b0, 1'b0, 1'b0, 8'h0F, 1'b1, 1'b1, 1'b1},
      {2'd2, 1'b1, 1'b0, 1'b0, 8'hF0, 1'b1, 1'b1, 1'b1},
      {2'd2, 1'b0, 1'b1, 1'b0, 8'h99, 1'b0, 1'b1, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_ack();
      @(negedge clk); rx_ack = 1'b1;
      @(negedge clk); rx_ack = 1'b0;
   endtask

   task automatic run_tx(input logic [7:0] d, input logic b9, input int bc, input int nb,
                         output logic [15:0] bits, output int blen);
      bits = '1;
      blen = 0;
      @(negedge clk); tx_data = d; tx_bit9 = b9; tx_load = 1'b1;
      @(negedge clk); tx_load = 1'b0;
      for (int c = 0; c < (nb + 2) * bc; c++) begin
         if ((c % bc) == bc / 2 && (c / bc) < 16) bits[c / bc] = txd;
         if (tx_busy) blen++;
         @(negedge clk);
      end
   endtask

   task automatic rx_send(input logic [15:0] bits, input int nb);
      for (int i = 0; i < nb; i++) begin
         rx_drv = bits[i];
         repeat (EXT_BIT) @(negedge clk);
      end
      rx_drv = 1'b1;
      repeat (EXT_BIT) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] bits;
      int          blen;
      logic [7:0]  last_data;
      last_data = 8'h00;

      repeat (5) @(negedge clk);
      // R1: reset state
      chk("R1 txd idle", {31'd0, txd}, 32'd1);
      chk("R1 busy", {31'd0, tx_busy}, 32'd0);
      chk("R1 flags", {29'd0, rx_done, rx_ferr, rx_ovr}, 32'd0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1 after release", {30'd0, txd, tx_busy}, 32'd2);

      // Loopback vector walk: R2 R3 R4 R5 R6 R8 R9 R10
      lb = 1'b1;
      for (int v = 0; v < NV; v++) begin
         logic [15:0] e;
         logic        nine;
         int          bc;
         int          nb;
         int          st;
         e = VEC[v];
         @(negedge clk);
         mode_sel = e[15:14];
         rate_dbl = e[13];
         two_stop = e[12];
         mp_en    = e[11];
         nine     = (e[15:14] != 2'd0);
         bc       = (e[15:14] == 2'd2) ? (e[13] ? 32 : 64) : EXT_BIT;
         nb       = 10 + int'(nine) + int'(e[12]);
         run_tx(e[10:3], e[2], bc, nb, bits, blen);
         chk($sformatf("R2 v%0d start", v), {31'd0, bits[0]}, 32'd0);
         chk($sformatf("R2 v%0d data", v), {24'd0, bits[8:1]}, {24'd0, e[10:3]});
         st = 9;
         if (nine) begin
            chk($sformatf("R2 v%0d bit9", v), {31'd0, bits[9]}, {31'd0, e[2]});
            st = 10;
         end
         chk($sformatf("R2 v%0d stop", v), {31'd0, bits[st]}, 32'd1);
         chk($sformatf("R3 R4 R5 v%0d busy length ok (len=%0d)", v, blen),
             {31'd0, (blen >= nb * bc - 8) && (blen <= nb * bc + 8)}, 32'd1);
         chk($sformatf("R8 R9 R10 v%0d done", v), {31'd0, rx_done}, {31'd0, e[1]});
         if (e[1]) begin
            chk($sformatf("R6 v%0d rx data", v), {24'd0, rx_data}, {24'd0, e[10:3]});
            chk($sformatf("R6 v%0d rx bit9", v), {31'd0, rx_bit9}, {31'd0, e[0]});
            chk($sformatf("R11 v%0d no ferr", v), {31'd0, rx_ferr}, 32'd0);
            last_data = e[10:3];
            do_ack();
         end else begin
            chk($sformatf("R8 v%0d data kept", v), {24'd0, rx_data}, {24'd0, last_data});
            chk($sformatf("R8 v%0d no ovr", v), {31'd0, rx_ovr}, 32'd0);
         end
      end

      // R3: load while busy is ignored
      @(negedge clk);
      mode_sel = 2'd1; rate_dbl = 1'b0; two_stop = 1'b0; mp_en = 1'b0;
      tx_data = 8'h11; tx_bit9 = 1'b0; tx_load = 1'b1;
      @(negedge clk); tx_load = 1'b0;
      repeat (100) @(negedge clk);
      tx_data = 8'h22; tx_bit9 = 1'b1; tx_load = 1'b1;
      @(negedge clk); tx_load = 1'b0;
      repeat (11 * EXT_BIT - 100 + 16) @(negedge clk);
      chk("R3 busy ends after one frame", {31'd0, tx_busy}, 32'd0);
      repeat (12 * EXT_BIT) @(negedge clk);
      chk("R3 second load ignored data", {24'd0, rx_data}, 32'h11);
      chk("R3 second load ignored ovr", {30'd0, rx_done, rx_ovr}, 32'd2);
      do_ack();

      // R7: short start pulse ignored
      lb = 1'b0;
      @(negedge clk); rx_drv = 1'b0;
      repeat (20) @(negedge clk);
      rx_drv = 1'b1;
      repeat (10 * EXT_BIT) @(negedge clk);
      chk("R7 glitch no frame", {31'd0, rx_done}, 32'd0);
      rx_send({5'b11111, 1'b1, 1'b0, 8'h4D, 1'b0}, 11);
      chk("R7 frame after glitch", {23'd0, rx_done, rx_data}, {23'd0, 1'b1, 8'h4D});
      do_ack();

      // R11: framing error, byte still stored
      rx_send({5'b11111, 1'b0, 1'b1, 8'h6B, 1'b0}, 11);
      chk("R11 ferr set", {30'd0, rx_done, rx_ferr}, 32'd3);
      chk("R11 data stored", {23'd0, rx_bit9, rx_data}, {23'd0, 1'b1, 8'h6B});
      do_ack();

      // R12: overrun keeps old data, ack clears
      rx_send({5'b11111, 1'b1, 1'b1, 8'h12, 1'b0}, 11);
      chk("R12 first frame", {30'd0, rx_done, rx_ovr}, 32'd2);
      rx_send({5'b11111, 1'b1, 1'b0, 8'h34, 1'b0}, 11);
      chk("R12 ovr set", {31'd0, rx_ovr}, 32'd1);
      chk("R12 old data kept", {23'd0, rx_bit9, rx_data}, {23'd0, 1'b1, 8'h12});
      do_ack();
      @(negedge clk);
      chk("R12 ack clears", {30'd0, rx_done, rx_ovr}, 32'd0);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule